// File: doc/BRIEF.md
# Notification Ring

A ring of register stages, one per router, that carries short status messages to every end node of an on-chip network. Each message names the router that sent it, holds one congestion bit for every output port of that router, and carries two voltage/frequency request flags (raise and lower). Every cycle each stage hands its contents to the next stage around the ring, so a message advances one position per clock.

A router posts a message through a ready/valid port on its own stage. It gets in only when the slot about to land in its stage is empty: traffic already on the ring always wins, and a router that is turned away keeps its request up and retries. While it waits the router may replace the data with its newest state; the block takes whatever is on the port in the cycle the request is accepted. Each node watches its stage's register through a delivery port. A message is therefore shown to every node, the sender included, exactly once. It is discarded when it comes back around to the stage that injected it, which frees that slot in the same cycle.

Top module: `notif_ring`

## Requirements
- R1: After reset every slot is empty: no delivery port shows a valid message and every post_ready is high.
- R2: A message held in stage i is held in stage (i+1) mod NODES on the next clock, with its payload unchanged, unless stage (i+1) mod NODES is its origin.
- R3: post_ready[i] is high exactly when the slot arriving at stage i is empty, or carries a message whose origin is i. A request with post_valid[i] and post_ready[i] both high places the message in stage i on the next clock.
- R4: When a message from the ring and a local request meet at a stage, the ring message takes the slot and the local request is not accepted in that cycle.
- R5: A message that reaches its origin stage again is removed. Each accepted message appears on the delivery port of each of the NODES nodes exactly once, and the ring ends up empty once posting stops.
- R6: The origin field of an injected message is the index of the stage that accepted it, encoded as an unsigned binary number of IDW bits.
- R7: The congestion bits (bit k of a node's PORTS-bit slice is output port k), the raise flag and the lower flag are delivered exactly as they stood at acceptance.
- R8: The payload taken is the one present in the accepting cycle. Values the requester showed in earlier cycles, while it was held off, are never delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| post_valid | input | NODES | Per-node request to inject a message |
| post_ready | output | NODES | Per-node acceptance: slot free this cycle |
| post_cong | input | NODES*PORTS | Per-node congestion bits, node i at [i*PORTS +: PORTS] |
| post_up | input | NODES | Per-node raise-level request flag |
| post_down | input | NODES | Per-node lower-level request flag |
| seen_valid | output | NODES | Stage i holds a message this cycle |
| seen_origin | output | NODES*IDW | Origin index of the message at stage i, [i*IDW +: IDW] |
| seen_cong | output | NODES*PORTS | Congestion bits of the message at stage i |
| seen_up | output | NODES | Raise flag of the message at stage i |
| seen_down | output | NODES | Lower flag of the message at stage i |

## Verification
The bench keeps a slot array of its own and compares every delivery port and every ready line on each clock. It targets five cases. In the first, one message must travel a full lap and then vanish; a design that compared the origin one stage off would either deliver it twice to one node or never show it to its last node. In the second, all nodes post at once, and a design that let local requests win would overwrite messages already in flight. In the third, the ring is kept full so that slots are freed only by removal at the origin; a design that failed to reuse the freed slot at once would drop ready too long. In the fourth, a held-off requester changes its payload every cycle, and stale data would show up at the delivery ports. Last, a drain compares the total number of deliveries with NODES times the number of accepted messages.

// File: rtl/notif_ring.sv
module notif_ring #(
  parameter int NODES = 8,
  parameter int PORTS = 5,
  localparam int IDW = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NODES-1:0]       post_valid,
  output logic [NODES-1:0]       post_ready,
  input  logic [NODES*PORTS-1:0] post_cong,
  input  logic [NODES-1:0]       post_up,
  input  logic [NODES-1:0]       post_down,
  output logic [NODES-1:0]       seen_valid,
  output logic [NODES*IDW-1:0]   seen_origin,
  output logic [NODES*PORTS-1:0] seen_cong,
  output logic [NODES-1:0]       seen_up,
  output logic [NODES-1:0]       seen_down
);

  logic             v_q   [NODES];
  logic [IDW-1:0]   org_q [NODES];
  logic [PORTS-1:0] cng_q [NODES];
  logic             up_q  [NODES];
  logic             dn_q  [NODES];

  for (genvar i = 0; i < NODES; i++) begin : g_st
    localparam int PRV = (i + NODES - 1) % NODES;
    localparam logic [IDW-1:0] ME = IDW'(i);

    logic arrive;
    assign arrive        = v_q[PRV] && (org_q[PRV] != ME);
    assign post_ready[i] = !arrive;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q[i]   <= 1'b0;
        org_q[i] <= '0;
        cng_q[i] <= '0;
        up_q[i]  <= 1'b0;
        dn_q[i]  <= 1'b0;
      end else if (arrive) begin
        v_q[i]   <= 1'b1;
        org_q[i] <= org_q[PRV];
        cng_q[i] <= cng_q[PRV];
        up_q[i]  <= up_q[PRV];
        dn_q[i]  <= dn_q[PRV];
      end else if (post_valid[i]) begin
        v_q[i]   <= 1'b1;
        org_q[i] <= ME;
        cng_q[i] <= post_cong[i*PORTS +: PORTS];
        up_q[i]  <= post_up[i];
        dn_q[i]  <= post_down[i];
      end else begin
        v_q[i]   <= 1'b0;
      end
    end

    assign seen_valid[i]                 = v_q[i];
    assign seen_origin[i*IDW +: IDW]     = org_q[i];
    assign seen_cong[i*PORTS +: PORTS]   = cng_q[i];
    assign seen_up[i]                    = up_q[i];
    assign seen_down[i]                  = dn_q[i];

    p_forward_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (v_q[PRV] && org_q[PRV] != ME) |=>
        (v_q[i] && org_q[i] == $past(org_q[PRV]) && cng_q[i] == $past(cng_q[PRV])));

    p_inject_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (post_valid[i] && post_ready[i]) |=> (v_q[i] && org_q[i] == ME));

    p_ring_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (post_valid[i] && !post_ready[i]) |=> (org_q[i] != ME));

    p_drop_at_origin_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (v_q[PRV] && org_q[PRV] == ME && !post_valid[i]) |=> !v_q[i]);

    p_payload_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (post_valid[i] && post_ready[i]) |=>
        (cng_q[i] == $past(post_cong[i*PORTS +: PORTS]) &&
         up_q[i] == $past(post_up[i]) && dn_q[i] == $past(post_down[i])));
  end

endmodule

// File: tb/notif_ring_bench.sv
module notif_ring_bench;
  localparam int N   = 8;
  localparam int P   = 5;
  localparam int IDW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [N-1:0]     post_valid = '0;
  logic [N-1:0]     post_ready;
  logic [N*P-1:0]   post_cong = '0;
  logic [N-1:0]     post_up = '0;
  logic [N-1:0]     post_down = '0;
  logic [N-1:0]     seen_valid;
  logic [N*IDW-1:0] seen_origin;
  logic [N*P-1:0]   seen_cong;
  logic [N-1:0]     seen_up;
  logic [N-1:0]     seen_down;

  notif_ring #(.NODES(N), .PORTS(P)) u_notif_ring (
    .clk(clk), .rst_n(rst_n),
    .post_valid(post_valid), .post_ready(post_ready),
    .post_cong(post_cong), .post_up(post_up), .post_down(post_down),
    .seen_valid(seen_valid), .seen_origin(seen_origin),
    .seen_cong(seen_cong), .seen_up(seen_up), .seen_down(seen_down)
  );

  int checks = 0;
  int fails = 0;
  int mv [N];
  int mo [N];
  int mc [N];
  int mu [N];
  int md [N];
  int accepted = 0;
  int delivered = 0;
  bit acc_last [N];
  logic [15:0] lf = 16'hACE1;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int prv(input int i);
    return (i + N - 1) % N;
  endfunction

  function automatic bit mready(input int i);
    return !(mv[prv(i)] != 0 && mo[prv(i)] != i);
  endfunction

  task automatic compare();
    for (int i = 0; i < N; i++) begin
      chk(post_ready[i] == mready(i), "R3/R4 ready", post_ready[i], mready(i));
      chk(seen_valid[i] == (mv[i] != 0), "R2/R5 valid", seen_valid[i], mv[i]);
      if (mv[i] != 0 && seen_valid[i]) begin
        delivered++;
        chk(int'(seen_origin[i*IDW +: IDW]) == mo[i], "R6 origin",
            seen_origin[i*IDW +: IDW], mo[i]);
        chk(int'(seen_cong[i*P +: P]) == mc[i], "R7/R8 cong", seen_cong[i*P +: P], mc[i]);
        chk(seen_up[i] == mu[i][0] && seen_down[i] == md[i][0], "R7 flags",
            {seen_up[i], seen_down[i]}, {mu[i][0], md[i][0]});
      end
    end
  endtask

  task automatic advance_model();
    int nv [N]; int no [N]; int nc [N]; int nu [N]; int nd [N];
    for (int i = 0; i < N; i++) begin
      int p;
      p = prv(i);
      acc_last[i] = 0;
      if (mv[p] != 0 && mo[p] != i) begin
        nv[i] = 1; no[i] = mo[p]; nc[i] = mc[p]; nu[i] = mu[p]; nd[i] = md[p];
      end else if (post_valid[i]) begin
        nv[i] = 1; no[i] = i; nc[i] = int'(post_cong[i*P +: P]);
        nu[i] = post_up[i]; nd[i] = post_down[i];
        acc_last[i] = 1;
        accepted++;
      end else begin
        nv[i] = 0; no[i] = mo[i]; nc[i] = mc[i]; nu[i] = mu[i]; nd[i] = md[i];
      end
    end
    for (int i = 0; i < N; i++) begin
      mv[i] = nv[i]; mo[i] = no[i]; mc[i] = nc[i]; mu[i] = nu[i]; md[i] = nd[i];
    end
  endtask

  task automatic next_lf();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  // mode 0: release only; 1: repost continuously; 2: node 5 churns payload while held off
  task automatic cycle(input int mode);
    @(negedge clk);
    compare();
    for (int i = 0; i < N; i++) begin
      if (acc_last[i]) post_valid[i] = 1'b0;
      if (mode >= 1 && !post_valid[i]) begin
        next_lf();
        post_valid[i] = lf[0] | lf[3];
        post_cong[i*P +: P] = lf[P+1:2];
        post_up[i] = lf[8];
        post_down[i] = lf[9];
      end else if (mode == 2 && i == 5 && post_valid[i]) begin
        next_lf();
        post_cong[i*P +: P] = lf[P-1:0];
        post_up[i] = lf[7];
        post_down[i] = lf[11];
      end
    end
    advance_model();
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      mv[i] = 0; mo[i] = 0; mc[i] = 0; mu[i] = 0; md[i] = 0; acc_last[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(seen_valid == '0, "R1 empty", seen_valid, 0);
    chk(post_ready == '1, "R1 ready", post_ready, 255);

    // single message from node 2, full lap
    post_valid[2] = 1'b1;
    post_cong[2*P +: P] = 5'b10110;
    post_up[2] = 1'b1;
    advance_model();
    for (int k = 0; k < 12; k++) cycle(0);
    chk(delivered == N, "R5 single lap count", delivered, N);

    // all nodes post at once
    for (int i = 0; i < N; i++) begin
      post_valid[i] = 1'b1;
      post_cong[i*P +: P] = P'(i * 3 + 1);
      post_up[i] = i[0];
      post_down[i] = i[1];
    end
    advance_model();
    for (int k = 0; k < 20; k++) cycle(0);

    // saturated ring, then payload churn on a held-off node (R8)
    for (int k = 0; k < 60; k++) cycle(1);
    for (int k = 0; k < 60; k++) cycle(2);

    // drain
    for (int k = 0; k < 200; k++) cycle(0);
    chk(seen_valid == '0, "R5 ring drained", seen_valid, 0);
    chk(post_valid == '0, "R3 all requests accepted", post_valid, 0);
    chk(delivered == N * accepted, "R5 exactly-once delivery", delivered, N * accepted);
    done = 1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (5000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finish");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule